// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Arbiter

This block lets several interrupt sources share one request line to a processor. Each source owns a slot in a chain. The slot request lines are combined into one interrupt request. When the processor answers with an acknowledge, a grant enable enters the chain at slot 1 and moves from slot to slot. A slot that is not requesting passes the enable on to the next slot. The first requesting slot in the chain keeps the enable, and every slot after it sees the enable low. That slot therefore wins.

The block returns the winner's 1-based position as a binary vector, with a one-cycle valid strobe. If the enable reaches the end of the chain without being taken, the vector is all ones, which marks a spurious acknowledge. The block keeps no record of requests. A device holds its request until its own service routine clears it at the source, so a request that is still held wins again on the next acknowledge.

A small controller paces the exchange. Its states are:
- `S_IDLE`: waiting for an acknowledge.
- `S_VECTOR`: presenting the vector for one cycle.
- `S_HOLD`: waiting for the acknowledge to drop.

Its transitions are:
- `ack_seen` (`S_IDLE` to `S_VECTOR`): the acknowledge is sampled high.
- `ack_held` (`S_VECTOR` to `S_HOLD`): the acknowledge is still high.
- `ack_short` (`S_VECTOR` to `S_IDLE`): the acknowledge is already low.
- `ack_released` (`S_HOLD` to `S_IDLE`): the acknowledge goes low.

Top module: `intr_chain_arbiter`

## Requirements
- R1: `int_req` is high in the same cycle whenever any bit of `dev_req` is high, and low when all bits are low. Bit i of `dev_req` belongs to slot i+1.
- R2: The winner is the lowest-numbered slot whose request is high at the clock edge where the acknowledge is captured. Slot 1 has the highest priority.
- R3: The vector equals the winner's 1-based slot number in binary, zero-extended to `ID_W` bits.
- R4: If no slot requests at the capture edge, the vector is all ones (7 for the default of 4 slots).
- R5: `vec_valid` is high for exactly one cycle. That cycle directly follows the clock edge at which `int_ack` is first sampled high while idle.
- R6: Holding `int_ack` high produces no further vector. A new vector needs `int_ack` to go low and then high again.
- R7: `vec_out` is all zeros whenever `vec_valid` is low.
- R8: After reset, `vec_valid` is 0 and `vec_out` is 0.
- R9: The block stores no request. A request still held after its vector wins the next acknowledge again.
- R10: Changing `dev_req` after the capture edge does not change the vector being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_SLOTS | Per-slot request lines; bit 0 is slot 1 |
| int_ack | input | 1 | Acknowledge from the processor; also the enable fed into slot 1 |
| int_req | output | 1 | Combined request to the processor |
| vec_out | output | ID_W | Winner slot number, or all ones when no slot requested |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` |

## Verification
A break in the chain enable would appear in the cycle after the acknowledge. It would show as a lower-priority slot number or a false spurious code on `vec_out`. A controller stuck in the vector state, or failing to wait for the acknowledge to drop, would show as a strobe longer than one cycle or as a second strobe during a held acknowledge. The sweep applies every request pattern of a four-slot chain. For each pattern it checks the strobe cycle, the vector value, and the quiet cycles that follow.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_VECTOR = 2'd1,
        S_HOLD   = 2'd2
    } arb_state_t;
endpackage

// File: rtl/intr_chain_link.sv
// One slot of the chain: keeps the enable when requesting, else passes it on.
module intr_chain_link (
    input  logic en_in,
    input  logic slot_req,
    output logic en_out,
    output logic slot_win
);
    assign slot_win = en_in & slot_req;
    assign en_out   = en_in & ~slot_req;
endmodule

// File: rtl/intr_vector_enc.sv
// Turns the one-hot win vector into a 1-based slot number.
// chain_tail high means the enable passed every slot: spurious code.
module intr_vector_enc #(
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 3
) (
    input  logic [NUM_SLOTS-1:0] slot_win,
    input  logic                 chain_tail,
    output logic [ID_W-1:0]      vec_code
);
    always_comb begin
        vec_code = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_win[i]) begin
                vec_code = vec_code | ID_W'(i + 1);
            end
        end
        if (chain_tail) begin
            vec_code = '1;
        end
    end
endmodule

// File: rtl/intr_ack_fsm.sv
module intr_ack_fsm
    import intr_chain_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack,
    input  logic [ID_W-1:0] code_in,
    output logic [ID_W-1:0] vec_out,
    output logic            vec_valid
);
    arb_state_t      state_q, state_d;
    logic [ID_W-1:0] code_q;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (ack) state_d = S_VECTOR;              // ack_seen
            S_VECTOR: state_d = ack ? S_HOLD : S_IDLE;          // ack_held / ack_short
            S_HOLD:   if (!ack) state_d = S_IDLE;               // ack_released
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && ack) begin
                code_q <= code_in;
            end
        end
    end

    // outputs
    always_comb begin
        vec_valid = 1'b0;
        vec_out   = '0;
        unique case (state_q)
            S_VECTOR: begin
                vec_valid = 1'b1;
                vec_out   = code_q;
            end
            S_IDLE, S_HOLD: begin
                vec_valid = 1'b0;
                vec_out   = '0;
            end
            default: begin
                vec_valid = 1'b0;
                vec_out   = '0;
            end
        endcase
    end
endmodule

// File: rtl/intr_chain_arbiter.sv
module intr_chain_arbiter #(
    parameter int NUM_SLOTS = 4,
    localparam int ID_W     = $clog2(NUM_SLOTS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] dev_req,
    input  logic                 int_ack,
    output logic                 int_req,
    output logic [ID_W-1:0]      vec_out,
    output logic                 vec_valid
);
    logic [NUM_SLOTS:0]   chain_en;
    logic [NUM_SLOTS-1:0] slot_win;
    logic [ID_W-1:0]      vec_code;

    assign int_req     = |dev_req;
    assign chain_en[0] = int_ack;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        intr_chain_link u_link (
            .en_in    (chain_en[g]),
            .slot_req (dev_req[g]),
            .en_out   (chain_en[g+1]),
            .slot_win (slot_win[g])
        );
    end

    intr_vector_enc #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_enc (
        .slot_win   (slot_win),
        .chain_tail (chain_en[NUM_SLOTS]),
        .vec_code   (vec_code)
    );

    intr_ack_fsm #(.ID_W(ID_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (int_ack),
        .code_in   (vec_code),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );
endmodule

// File: rtl/intr_chain_checker.sv
module intr_chain_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] dev_req,
    input logic                 int_ack,
    input logic                 int_req,
    input logic [ID_W-1:0]      vec_out,
    input logic                 vec_valid,
    input logic [NUM_SLOTS-1:0] slot_win
);
    p_req_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req != '0) |-> int_req);
    p_req_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req == '0) |-> !int_req);
    p_single_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_win));
    p_top_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(dev_req[0])) |-> (vec_out == ID_W'(1)));
    p_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ($past(dev_req) == '0)) |-> (vec_out == '1));
    p_real_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ($past(dev_req) != '0)) |-> (vec_out != '1));
    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    p_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack));
    p_quiet_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0));
endmodule

bind intr_chain_arbiter intr_chain_checker #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .int_ack   (int_ack),
    .int_req   (int_req),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .slot_win  (slot_win)
);

// File: tb/test_intr_chain_arbiter.sv
module test_intr_chain_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_req = '0;
    logic          int_ack = 1'b0;
    logic          int_req;
    logic [IW-1:0] vec_out;
    logic          vec_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_chain_arbiter #(.NUM_SLOTS(N)) i_intr_chain_arbiter (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .int_ack(int_ack),
        .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    function automatic int expect_vec(input int pat);
        for (int i = 0; i < N; i++) begin
            if (pat[i]) return i + 1;
        end
        return (1 << IW) - 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic one_ack(input int pat, input bit hold);
        int e;
        e = expect_vec(pat);
        @(negedge clk);
        dev_req = N'(pat);
        int_ack = 1'b0;
        #1;
        check(int_req == (pat != 0), "R1 int_req", int_req, pat != 0);
        check(vec_valid == 1'b0, "R5 no strobe before ack", vec_valid, 0);
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        check(vec_valid == 1'b1, "R5 strobe after ack", vec_valid, 1);
        check(vec_out == IW'(e), "R2 R3 R4 vector", vec_out, e);
        if (!hold) begin
            dev_req = ~N'(pat);
            #1;
            check(vec_out == IW'(e), "R10 vector stable", vec_out, e);
        end
        @(negedge clk);
        check(vec_valid == 1'b0, "R5 one-cycle strobe", vec_valid, 0);
        check(vec_out == '0, "R7 zero when not valid", vec_out, 0);
        @(negedge clk);
        check(vec_valid == 1'b0, "R6 no re-strobe on held ack", vec_valid, 0);
        int_ack = 1'b0;
        @(negedge clk);
        check(vec_valid == 1'b0, "R6 idle after release", vec_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(vec_valid == 1'b0, "R8 reset strobe", vec_valid, 0);
        check(vec_out == '0, "R8 reset vector", vec_out, 0);
        rst_n = 1'b1;
        for (int p = 0; p < (1 << N); p++) begin
            one_ack(p, 1'b0);
        end
        // R9: request held across two acknowledges wins both times
        for (int p = 1; p < (1 << N); p++) begin
            one_ack(p, 1'b1);
            one_ack(p, 1'b1);
        end
        // R6: ack held long, single strobe only
        @(negedge clk);
        dev_req = 4'b0100;
        int_ack = 1'b1;
        @(negedge clk);
        check(vec_valid && vec_out == 3, "R6 first strobe slot 3", vec_out, 3);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(vec_valid == 1'b0, "R6 held ack quiet", vec_valid, 0);
        end
        int_ack = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule